// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins an A bus and a B bus, each 18 bits wide. Data moves A to B and B to A over two independent paths. Each path has one storage element that works in one of three ways, chosen on every cycle:

- **Pass:** while its latch-enable is high, the input flows straight to the output.
- **Hold:** while latch-enable is low and its capture clock is quiet, the element keeps its value.
- **Capture:** while latch-enable is low, a low-to-high change of the capture clock stores the present input.

The two paths are mirror images. The A-to-B output enable is active high and the B-to-A output enable is active low.

Pads are not modelled. Each bus has a data-out vector and a single drive-enable bit. A drive-enable of 0 stands for high impedance. The data-out vector keeps showing the storage state even while its drive-enable is 0. The capture clocks are ordinary inputs. They are sampled on the system clock `clk`, and a rising change is recognised at the first `clk` edge that sees them high. A `contend` flag reports when both directions are enabled together. The flag does not change either drive-enable.

Top module: `bus_xcvr18`

## Requirements
- R1: Each direction is W bits wide, with W = 18 by default.
- R2: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, with no clock edge in between. While `ba_le` is 1, `a_out` equals `b_in` in the same way.
- R3: While the latch-enable is 0 and no rising capture-clock change is sampled, the output holds its value. This is true whether the capture clock sits at 0 or at 1, and when it falls. Changes on the input have no effect.
- R4: While the latch-enable is 0, a `clk` edge that samples the capture clock at 1, after it was sampled at 0 on the previous edge, stores the input sampled at that edge. The output shows the stored value from that edge onward.
- R5: `b_drv` equals `ab_oe`. The A-to-B enable is active high.
- R6: `a_drv` equals the inverse of `ba_oe_n`. The B-to-A enable is active low.
- R7: The storage keeps following (R2) and capturing (R4) while its drive-enable is 0. The result is visible on the data-out vector when it is enabled again.
- R8: `contend` is 1 exactly when `a_drv` and `b_drv` are both 1. Both drive-enables stay asserted; nothing picks a winner.
- R9: Reset clears both storage elements to 0. It presets each sampled capture-clock level to 1, so a clock that is already high when reset ends causes no capture.
- R10: Activity on one direction never changes the other direction's data-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples capture clocks and updates storage |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | W | Data arriving from the A bus |
| b_in | input | W | Data arriving from the B bus |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable (1 = pass) |
| ab_clk | input | 1 | A-to-B capture clock, rising change stores |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = pass) |
| ba_clk | input | 1 | B-to-A capture clock, rising change stores |
| b_out | output | W | Data toward the B bus |
| b_drv | output | 1 | Drive enable for the B bus (0 = high impedance) |
| a_out | output | W | Data toward the A bus |
| a_drv | output | 1 | Drive enable for the A bus (0 = high impedance) |
| contend | output | 1 | Both directions enabled at once |

## Verification
Two functions can land on the same `clk` edge: the release of pass mode, when the latch-enable falls, and a rising change of the capture clock. The bench provokes this by dropping the latch-enable and raising the capture clock at the same instant, then changing the input. It expects the value sampled at that edge to be stored and held, not the later input. Contention is the second overlap. Both enables are asserted together, and the bench requires `contend` high while both drive-enables stay at 1.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DATA_W = 18;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_HOLD    = 2'd1,
    MODE_CAPTURE = 2'd2
  } store_mode_e;
endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  // Preset high so a level already high at reset exit is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W           = xcvr_pkg::DATA_W,
  parameter bit OE_ACT_LOW  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  input  logic         le,
  input  logic         cap_clk,
  input  logic         oe,
  output logic [W-1:0] d_out,
  output logic         drv
);
  import xcvr_pkg::*;

  logic         cap_rise;
  logic [W-1:0] store_q;
  store_mode_e  mode;

  xcvr_rise_det u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (cap_clk),
    .rise  (cap_rise)
  );

  always_comb begin
    if (le)            mode = MODE_PASS;
    else if (cap_rise) mode = MODE_CAPTURE;
    else               mode = MODE_HOLD;
  end

  // Storage keeps working regardless of the output enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else begin
      case (mode)
        MODE_PASS, MODE_CAPTURE: store_q <= d_in;
        default:                 store_q <= store_q;
      endcase
    end
  end

  // Pass mode bypasses the register so the output follows in the same cycle.
  assign d_out = (mode == MODE_PASS) ? d_in : store_q;

  generate
    if (OE_ACT_LOW) begin : g_oe_low
      assign drv = ~oe;
    end else begin : g_oe_high
      assign drv = oe;
    end
  endgenerate
endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18 #(
  parameter int W = xcvr_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  output logic         contend
);
  xcvr_lane #(.W(W), .OE_ACT_LOW(1'b0)) u_ab (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_in    (a_in),
    .le      (ab_le),
    .cap_clk (ab_clk),
    .oe      (ab_oe),
    .d_out   (b_out),
    .drv     (b_drv)
  );

  xcvr_lane #(.W(W), .OE_ACT_LOW(1'b1)) u_ba (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_in    (b_in),
    .le      (ba_le),
    .cap_clk (ba_clk),
    .oe      (ba_oe_n),
    .d_out   (a_out),
    .drv     (a_drv)
  );

  // Reported only; neither drive enable is altered.
  assign contend = a_drv & b_drv;
endmodule

// File: rtl/bus_xcvr18_chk.sv
module bus_xcvr18_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_oe,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic         ba_clk,
  input logic [W-1:0] b_out,
  input logic         b_drv,
  input logic [W-1:0] a_out,
  input logic         a_drv,
  input logic         contend
);
  logic ab_ck_q, ba_ck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_ck_q <= 1'b1;
      ba_ck_q <= 1'b1;
    end else begin
      ab_ck_q <= ab_clk;
      ba_ck_q <= ba_clk;
    end
  end

  a_r2_ab_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |-> (b_out == a_in));
  a_r2_ba_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ba_le |-> (a_out == b_in));

  a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !(ab_clk && !ab_ck_q)) |=> (ab_le || $stable(b_out)));
  a_r3_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !(ba_clk && !ba_ck_q)) |=> (ba_le || $stable(a_out)));

  a_r4_ab_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && ab_clk && !ab_ck_q) |=> (ab_le || b_out == $past(a_in)));
  a_r4_ba_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && ba_clk && !ba_ck_q) |=> (ba_le || a_out == $past(b_in)));

  a_r5_b_drive: assert property (@(posedge clk) disable iff (!rst_n)
    b_drv == ab_oe);
  a_r6_a_drive: assert property (@(posedge clk) disable iff (!rst_n)
    a_drv == !ba_oe_n);
  a_r8_contend: assert property (@(posedge clk) disable iff (!rst_n)
    contend == (a_drv && b_drv));
endmodule

bind bus_xcvr18 bus_xcvr18_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
  .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
  .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
  .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv),
  .contend(contend)
);

// File: tb/bus_xcvr18_bench.sv
`timescale 1ns/1ps
module bus_xcvr18_bench;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe = 1'b0, ab_le = 1'b0, ab_clk = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0;
  logic [W-1:0] b_out, a_out;
  logic b_drv, a_drv, contend;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_xcvr18 #(.W(W)) u_bus_xcvr18 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv),
    .contend(contend)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Leaves time 1 ns after a rising clk edge.
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset;
    ab_clk = 1'b1; ba_clk = 1'b1; a_in = 18'h2A5A5; b_in = 18'h15A5A;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(2);
    chk("R9 b_out after reset, clock high", b_out, '0);
    chk("R9 a_out after reset, clock high", a_out, '0);
    chk("R5 b_drv low with ab_oe=0", {17'd0, b_drv}, 18'd0);
    chk("R6 a_drv low with ba_oe_n=1", {17'd0, a_drv}, 18'd0);
    chk("R1 width", W, 18);
  endtask

  task automatic t_pass;
    ab_le = 1'b1; ba_le = 1'b1;
    a_in = 18'h3FFFF; b_in = 18'h00001; #1;
    chk("R2 ab pass", b_out, 18'h3FFFF);
    chk("R2 ba pass", a_out, 18'h00001);
    a_in = 18'h12345; b_in = 18'h2BCDE; #0.5;
    chk("R2 ab pass same cycle", b_out, 18'h12345);
    chk("R2 ba pass same cycle", a_out, 18'h2BCDE);
    tick();
  endtask

  task automatic t_hold;
    // Capture clocks high when the latch enables fall.
    a_in = 18'h0AAAA; b_in = 18'h35555; tick();
    ab_le = 1'b0; ba_le = 1'b0;
    a_in = 18'h11111; b_in = 18'h22222; #0.5;
    chk("R3 ab hold clk high", b_out, 18'h0AAAA);
    chk("R3 ba hold clk high", a_out, 18'h35555);
    tick(3);
    chk("R3 ab hold clk high later", b_out, 18'h0AAAA);
    ab_clk = 1'b0; ba_clk = 1'b0; a_in = 18'h00F0F;
    tick(3);
    chk("R3 ab hold after falling/low clk", b_out, 18'h0AAAA);
    chk("R3 ba hold after falling/low clk", a_out, 18'h35555);
  endtask

  task automatic t_capture;
    ab_clk = 1'b0; tick();
    a_in = 18'h1C3C3; ab_clk = 1'b1;
    tick();
    chk("R4 ab capture on rising", b_out, 18'h1C3C3);
    a_in = 18'h0000F; tick(2);
    chk("R3 ab hold clk steady high after capture", b_out, 18'h1C3C3);
    ab_clk = 1'b0; tick();
    chk("R4 falling clk does not capture", b_out, 18'h1C3C3);
    // Latch enable falls on the same edge as the capture rising.
    ab_le = 1'b1; a_in = 18'h22222; tick();
    ab_le = 1'b0; ab_clk = 1'b1; a_in = 18'h3ABCD;
    tick();
    a_in = 18'h00777; #0.5;
    chk("R4 capture coinciding with pass release", b_out, 18'h3ABCD);
    tick();
    chk("R4 capture coinciding, held", b_out, 18'h3ABCD);
  endtask

  task automatic t_independent;
    logic [W-1:0] a_before;
    a_before = a_out;
    ab_clk = 1'b0; tick();
    a_in = 18'h2FEED; ab_clk = 1'b1; tick();
    chk("R10 ab capture", b_out, 18'h2FEED);
    chk("R10 a_out untouched by ab activity", a_out, a_before);
    ba_clk = 1'b0; tick();
    b_in = 18'h1BEEF; ba_clk = 1'b1; tick();
    chk("R4 ba capture on rising", a_out, 18'h1BEEF);
    chk("R10 b_out untouched by ba activity", b_out, 18'h2FEED);
  endtask

  task automatic t_disabled;
    ab_oe = 1'b0; ba_oe_n = 1'b1; #0.5;
    chk("R5 b high-z", {17'd0, b_drv}, 18'd0);
    chk("R6 a high-z", {17'd0, a_drv}, 18'd0);
    ab_clk = 1'b0; tick();
    a_in = 18'h13579; ab_clk = 1'b1; tick();
    ab_le = 1'b1; b_in = 18'h02468; ba_le = 1'b1; tick();
    ba_le = 1'b0; b_in = 18'h3FFFF; tick();
    ab_le = 1'b0; a_in = 18'h00000;
    ab_oe = 1'b1; ba_oe_n = 1'b0; #0.5;
    chk("R7 ab stored while disabled", b_out, 18'h13579);
    chk("R7 ba followed while disabled", a_out, 18'h02468);
  endtask

  task automatic t_enables;
    ab_oe = 1'b1; ba_oe_n = 1'b1; #0.5;
    chk("R5 b_drv high", {17'd0, b_drv}, 18'd1);
    chk("R8 no contention ab only", {17'd0, contend}, 18'd0);
    ab_oe = 1'b0; ba_oe_n = 1'b0; #0.5;
    chk("R6 a_drv high on low enable", {17'd0, a_drv}, 18'd1);
    chk("R5 b_drv low", {17'd0, b_drv}, 18'd0);
    ab_oe = 1'b1; ba_oe_n = 1'b0; #0.5;
    chk("R8 contention flagged", {17'd0, contend}, 18'd1);
    chk("R8 a_drv kept", {17'd0, a_drv}, 18'd1);
    chk("R8 b_drv kept", {17'd0, b_drv}, 18'd1);
    tick();
    ab_oe = 1'b0; ba_oe_n = 1'b1; #0.5;
    chk("R8 contention cleared", {17'd0, contend}, 18'd0);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 18'd0, 18'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pass();
    t_hold();
    t_capture();
    t_independent();
    t_disabled();
    t_enables();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule